// File: doc/BRIEF.md
# Rotating Daisy-Chain Bus Arbiter

This block decides which of several bus-master units may drive a shared system bus. Each unit has its own arbiter stage. A priority token enters the chain at a head stage and passes from each stage's priority output to the next stage's priority input. A stage that is requesting keeps the token, and every stage after it sees its priority input low. The requesting stage that holds the token takes the bus, but only while the shared busy line is low.

A mode input selects one of two priority schemes. In fixed mode the head is always unit 1, so the unit nearest the chain start wins. In rotating mode the head is the unit just after the last bus owner, so the last owner drops to lowest priority. An owner keeps its grant until it asserts its own release. The busy line falls one cycle later, and the next arbitration takes place on the following clock edge.

Units are numbered 1 to 4 from the chain start. Unit k maps to bit k-1 of every per-unit vector.

Top module: `rot_daisy_arbiter`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle.
- R2: A grant is issued only on a rising edge at which `busy_o` was low. Requests made while `busy_o` is high grant nothing.
- R3: The head stage sees `prio_in_o` high. Each stage drives `prio_out_o` high exactly when its `prio_in_o` is high and its `req_i` bit is low, and that output is the `prio_in_o` of the next stage, with stage 4 wrapping to stage 1. A new grant goes only to a stage whose `prio_in_o` and `req_i` were both high.
- R4: With `mode_rotate_i` low (fixed mode), the head is unit 1 (bit 0), so the requesting unit with the lowest bit index wins.
- R5: With `mode_rotate_i` high (rotating mode), the head is the unit after the most recent owner, wrapping from unit 4 to unit 1. The recorded owner is updated on every grant in either mode.
- R6: A grant stays high until its owner's `rel_i` bit is high at a clock edge. A `rel_i` bit from a unit that holds no grant has no effect.
- R7: `busy_o` rises on the same edge as a grant and stays high while any grant is held. It falls one edge after the grant clears, and a waiting request is granted on the following edge.
- R8: Reset (active-low `rst_n`) clears all grants and `busy_o`, and sets the rotation head to unit 1.
- R9: With no request present, no grant is issued and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_rotate_i | input | 1 | 0 = fixed priority from unit 1, 1 = rotating priority |
| req_i | input | N | Bus request, one bit per unit |
| rel_i | input | N | Release of an owned grant, one bit per unit |
| grant_o | output | N | Bus grant, one-hot or zero |
| busy_o | output | 1 | Shared bus-taken line |
| prio_in_o | output | N | Priority input link seen by each stage |
| prio_out_o | output | N | Priority output link of each stage |

## Verification
A head pointer that is wrong shows on `prio_out_o` at once, in the same cycle that requests are applied. In rotating mode it also grants the wrong unit on the next edge. A grant register that clears too early, or that obeys another unit's release, shows on `grant_o` one edge after the release stimulus. A busy register that lags or leads shows as `busy_o` falling on the wrong edge, or as a second grant one edge too soon. The bench compares grant, busy and link values against a queue of expected items. It computes each item from the priority rules, with its own model of the last owner.

// File: rtl/arb_pkg.sv
// Package arb_pkg
// Shared helpers for the daisy-chain arbiter.
// Assumes unit indices are 0-based bit positions (unit k is index k-1).
package arb_pkg;

    // Index that follows cur in a ring of n stages.
    function automatic int ring_next(input int cur, input int n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/arb_prio_ring.sv
// Module arb_prio_ring
// Propagates the priority token around the ring of stages.
// The token is injected at the head stage and ripples stage by stage;
// a requesting stage absorbs it. The ring is opened at the head, so no
// combinational loop exists.
// Assumes head < N.
module arb_prio_ring #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0] head,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  prio_in
);

    logic          carry;
    logic [IW-1:0] idx;

    // Walk the ring from the head and hand each stage the current token.
    always_comb begin
        prio_in = '0;
        carry   = 1'b1;
        idx     = head;
        for (int off = 0; off < N; off++) begin
            idx          = IW'((int'(head) + off) % N);
            prio_in[idx] = carry;
            carry        = carry & ~req[idx];
        end
    end

endmodule

// File: rtl/arb_stage.sv
// Module arb_stage
// One arbiter stage: holds its unit's grant and forms its priority output.
// A stage wins when it has the token, is requesting and the bus is free.
// A grant is kept until the unit's own release.
// Assumes bus_free already accounts for every stage's grant.
module arb_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic prio_in,
    input  logic req,
    input  logic rel,
    input  logic bus_free,
    output logic prio_out,
    output logic win,
    output logic grant
);

    // Pass the token on only when this stage does not want the bus.
    assign prio_out = prio_in & ~req;
    assign win      = prio_in & req & bus_free;

    // Grant register: cleared by reset or own release, set by a win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= 1'b0;
        end else if (grant && rel) begin
            grant <= 1'b0;
        end else if (win) begin
            grant <= 1'b1;
        end
    end

endmodule

// File: rtl/arb_rot_ptr.sv
// Module arb_rot_ptr
// Tracks the rotation head (the unit after the last owner) and the shared
// busy line. Busy rises with a win and falls one edge after the last
// grant is gone.
// Assumes win is one-hot or zero.
module arb_rot_ptr #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  win,
    input  logic [N-1:0]  grant,
    output logic [IW-1:0] head,
    output logic          busy
);

    import arb_pkg::*;

    logic [IW-1:0] next_head;
    logic          any_win;

    // Encode the winning stage and point one step past it.
    always_comb begin
        next_head = head;
        any_win   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) begin
                next_head = IW'(ring_next(i, N));
                any_win   = 1'b1;
            end
        end
    end

    // Head pointer register, starting at unit 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else if (any_win) begin
            head <= next_head;
        end
    end

    // Busy register: set by a win, held by a grant, cleared one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else begin
            busy <= any_win | (|grant);
        end
    end

endmodule

// File: rtl/rot_daisy_arbiter.sv
// Module rot_daisy_arbiter
// Top of the shared-bus arbiter. It holds N chained stages, the token ring
// and the rotation/busy tracker. mode_rotate_i picks fixed priority
// (head = unit 1) or rotating priority (head = unit after last owner).
// Assumes synchronous active-low reset and requesters that hold req_i
// until they are granted.
module rot_daisy_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_rotate_i,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] rel_i,
    output logic [N-1:0] grant_o,
    output logic         busy_o,
    output logic [N-1:0] prio_in_o,
    output logic [N-1:0] prio_out_o
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] rot_head;
    logic [IW-1:0] head_sel;
    logic [N-1:0]  win_vec;
    logic          busy_q;

    // Choose the chain head from the mode input.
    assign head_sel = mode_rotate_i ? rot_head : '0;
    assign busy_o   = busy_q;

    arb_prio_ring #(.N(N), .IW(IW)) u_ring (
        .head    (head_sel),
        .req     (req_i),
        .prio_in (prio_in_o)
    );

    for (genvar g = 0; g < N; g++) begin : g_stage
        arb_stage u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .prio_in  (prio_in_o[g]),
            .req      (req_i[g]),
            .rel      (rel_i[g]),
            .bus_free (~busy_q),
            .prio_out (prio_out_o[g]),
            .win      (win_vec[g]),
            .grant    (grant_o[g])
        );
    end

    arb_rot_ptr #(.N(N), .IW(IW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .win   (win_vec),
        .grant (grant_o),
        .head  (rot_head),
        .busy  (busy_q)
    );

endmodule

// File: rtl/rot_daisy_arbiter_chk.sv
// Module rot_daisy_arbiter_chk
// Port-level checker bound to rot_daisy_arbiter.
// Assumes the same N and clocking as the arbiter.
module rot_daisy_arbiter_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_rotate_i,
    input logic [N-1:0] req_i,
    input logic [N-1:0] rel_i,
    input logic [N-1:0] grant_o,
    input logic         busy_o,
    input logic [N-1:0] prio_in_o,
    input logic [N-1:0] prio_out_o
);

    // R1
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2
    no_grant_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ((grant_o & ~$past(grant_o)) == '0));

    // R3
    grant_needs_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ((grant_o & ~$past(grant_o) & ~($past(prio_in_o) & $past(req_i))) == '0));

    // R6
    grant_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o & ~rel_i) != '0) |=>
            ((grant_o & $past(grant_o & ~rel_i)) == $past(grant_o & ~rel_i)));

    // R7
    busy_covers_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> busy_o);

    // R7
    busy_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && grant_o == '0) |=> !busy_o);

endmodule

bind rot_daisy_arbiter rot_daisy_arbiter_chk #(.N(N)) u_chk (.*);

// File: tb/tb_rot_daisy_arbiter.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected items, the monitor checks them.
module tb_rot_daisy_arbiter;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] rel = '0;
    logic [N-1:0] grant;
    logic         busy;
    logic [N-1:0] pin;
    logic [N-1:0] pout;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int head_m = 0;
    bit done = 1'b0;

    typedef struct {
        int           at;
        logic [N-1:0] g;
        logic         b;
        logic         cp;
        logic [N-1:0] po;
        string        tag;
    } exp_t;

    exp_t q[$];

    rot_daisy_arbiter #(.N(N)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_rotate_i (mode),
        .req_i         (req),
        .rel_i         (rel),
        .grant_o       (grant),
        .busy_o        (busy),
        .prio_in_o     (pin),
        .prio_out_o    (pout)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Cycle stamp.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every expected item that is due and compare it.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (grant !== e.g || busy !== e.b || (e.cp && pout !== e.po)) begin
                bad++;
                $display("FAIL %s: grant=%b exp=%b busy=%b exp=%b pout=%b exp=%b",
                         e.tag, grant, e.g, busy, e.b, pout, e.cp ? e.po : pout);
            end
        end
    end

    task automatic expect_at(input int off, input logic [N-1:0] g, input logic b,
                             input logic cp, input logic [N-1:0] po, input string tag);
        exp_t e;
        e.at = cyc + off; e.g = g; e.b = b; e.cp = cp; e.po = po; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Winner according to R4 / R5.
    function automatic int pick(input logic [N-1:0] r, input logic m, input int h);
        int start = m ? h : 0;
        for (int off = 0; off < N; off++) begin
            if (r[(start + off) % N]) return (start + off) % N;
        end
        return -1;
    endfunction

    // Expected chain outputs according to R3.
    function automatic logic [N-1:0] po_of(input logic [N-1:0] r, input logic m, input int h);
        logic [N-1:0] po = '0;
        logic c = 1'b1;
        int start = m ? h : 0;
        for (int off = 0; off < N; off++) begin
            po[(start + off) % N] = c & ~r[(start + off) % N];
            c = c & ~r[(start + off) % N];
        end
        return po;
    endfunction

    // One full grant/hold/release cycle starting on an idle bus.
    task automatic do_grant(input logic [N-1:0] r, input logic m, input string tag);
        int w;
        logic [N-1:0] wm;
        w = pick(r, m, head_m);
        wm = N'(1) << w;
        req = r;
        mode = m;
        expect_at(0, '0, 1'b0, 1'b1, po_of(r, m, head_m), {tag, " R3 chain links"});
        expect_at(1, wm, 1'b1, 1'b0, '0, {tag, " winner, R7 busy rises"});
        wait_cyc(1);
        rel = ~wm;
        expect_at(1, wm, 1'b1, 1'b0, '0, {tag, " R6 non-owner release ignored"});
        wait_cyc(1);
        rel = '0;
        expect_at(1, wm, 1'b1, 1'b0, '0, {tag, " R2 others blocked while busy"});
        wait_cyc(1);
        rel = wm;
        expect_at(1, '0, 1'b1, 1'b0, '0, {tag, " R7 busy lingers one cycle"});
        expect_at(2, '0, 1'b0, 1'b0, '0, {tag, " R7 busy drops"});
        wait_cyc(1);
        rel = '0;
        wait_cyc(1);
        req = '0;
        head_m = (w + 1) % N;
    endtask

    // Driver: the scenario sequence.
    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        expect_at(0, '0, 1'b0, 1'b1, '1, "R8 reset state");
        wait_cyc(1);
        req = '0;
        expect_at(1, '0, 1'b0, 1'b1, '1, "R9 idle no grant");
        expect_at(2, '0, 1'b0, 1'b0, '0, "R9 idle busy low");
        wait_cyc(2);
        do_grant(4'b1111, 1'b0, "R4 fixed all");
        do_grant(4'b1100, 1'b0, "R4 fixed upper");
        do_grant(4'b1111, 1'b1, "R5 rotate after fixed owner");
        do_grant(4'b0110, 1'b1, "R5 rotate wrap head");
        do_grant(4'b0011, 1'b1, "R5 rotate passes owner");
        do_grant(4'b1000, 1'b1, "R5 rotate single");
        do_grant(4'b1010, 1'b0, "R4 fixed ignores pointer");
        do_grant(4'b1010, 1'b1, "R5 rotate after unit2");
        wait_cyc(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule